// File: doc/BRIEF.md
# Ethernet MAC Interrupt Event and Mask Controller

This block collects the interrupt-worthy events of an Ethernet MAC into a 32-bit event register and pairs it with a mask register. It drives one registered interrupt request line toward the system interrupt controller. Most events arrive as single-cycle pulses from neighbouring logic: the transmit and receive paths, the management-interface shifter and the bus master. Three events are derived inside the block. Two length watchdogs compare running byte counts against a programmable frame-length ceiling, one for receive and one for transmit. A stop tracker reports when a requested graceful transmit halt has taken effect.

Software reaches both registers through a small synchronous register port. Event bits are cleared by writing ones. Bit 21 of the event register is a read-only copy of the interrupt line, and the mask does not affect it.

Top module: `eth_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the event register, the mask register, the interrupt line and the read data are all zero.
- R2: Event bits sit at these positions: 31 heartbeat error, 30 oversize receive, 29 oversize transmit, 28 stop complete, 27 transmit frame, 26 transmit buffer, 25 receive frame, 24 receive buffer, 23 management done, 22 bus error. An input pulse sets its bit on the next clock edge. The event register reads at word offset 0. Read data is registered and reflects the register contents at the edge after the address is presented. Bits 20 to 0 always read zero.
- R3: A write to offset 0 clears every event bit in 31..22 whose write-data bit is one. Bits written with zero keep their value.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: The interrupt line is a register loaded with the OR over bits 31..22 of (event AND mask). It therefore rises one edge after both the event bit and its mask bit are set.
- R6: Bit 21 of the event read equals the interrupt line as registered at the edge that captures the read data. The mask does not gate it, and writes to it are ignored.
- R7: The mask register reads and writes at offset 4, and only its bits 31..22 are stored. Its other bits read zero. Any other offset reads zero, and writes to it change nothing.
- R8: The receive length watchdog arms on a receive start-of-frame and counts receive byte strobes. A start strobe in the same cycle as a byte counts that byte as the first of the new frame. On the first byte whose index exceeds the ceiling, it sets bit 30 two edges later and disarms until the next start.
- R9: The transmit length watchdog follows the same rule with the transmit strobes and bit 29, and it never stops the frame.
- R10: A stop request, held high, sets bit 28 once, on the first cycle in which the request is high and the transmitter reports no frame in progress. If no frame is in progress at the time of the request, this is the same cycle. Dropping the request before that cycle cancels it. A new request needs the line low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_err_i | input | 1 | Heartbeat-missing pulse |
| tx_frame_i | input | 1 | Transmit frame done pulse |
| tx_buf_i | input | 1 | Transmit buffer done pulse |
| rx_frame_i | input | 1 | Receive frame done pulse |
| rx_buf_i | input | 1 | Receive buffer done pulse |
| mgmt_done_i | input | 1 | Management transfer done pulse |
| bus_err_i | input | 1 | Bus error pulse |
| max_frame_len_i | input | LEN_W | Frame-length ceiling in bytes |
| rx_sof_i | input | 1 | Receive start-of-frame strobe |
| rx_byte_i | input | 1 | Receive byte strobe |
| tx_sof_i | input | 1 | Transmit start-of-frame strobe |
| tx_byte_i | input | 1 | Transmit byte strobe |
| gstop_req_i | input | 1 | Graceful stop request level |
| tx_active_i | input | 1 | Transmit frame in progress level |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets a clearing write that lands on the same edge as a new pulse. A design that lets the clear win would silently drop that event. It checks that the summary bit tracks the interrupt line and not the raw events, because a masked-but-pending event must leave bit 21 low. For the watchdogs, it probes the byte exactly at the ceiling, bytes after a firing within the same frame, and bytes with no start strobe. An off-by-one design fires a byte early, and a design that never disarms raises repeated events. The stop tracker is driven with requests made while a frame is in progress, while the transmitter is idle, and withdrawn before completion. A wrong tracker fires too early, fires twice, or fires after a cancel.

// File: rtl/eth_irq_pkg.sv
package eth_irq_pkg;
  localparam int REG_W   = 32;
  localparam int EV_TOP  = 31;
  localparam int EV_LOW  = 22;
  localparam int SUM_BIT = 21;
  localparam int NUM_EV  = EV_TOP - EV_LOW + 1;
  localparam int NUM_BABBLE = 2;

  typedef logic [NUM_EV-1:0] ev_bits_t;

  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_WAIT = 2'd1,
    GS_HELD = 2'd2
  } gs_state_t;
endpackage

// File: rtl/eirq_babble_det.sv
module eirq_babble_det #(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sof_i,
  input  logic             byte_i,
  input  logic [LEN_W-1:0] max_len_i,
  output logic             evt_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             armed_q;
  logic             evt_q;
  logic [LEN_W-1:0] base;
  logic             live;
  logic             over;

  // a start strobe restarts the count in its own cycle
  assign base = sof_i ? '0 : cnt_q;
  assign live = sof_i | armed_q;
  assign over = byte_i && live && (base == max_len_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= over;
      if (over)       armed_q <= 1'b0;
      else if (sof_i) armed_q <= 1'b1;
      if (byte_i && live && !over) cnt_q <= base + LEN_W'(1);
      else if (sof_i)              cnt_q <= '0;
    end
  end

  assign evt_o = evt_q;

  // R8, R9: an oversize event always follows a byte strobe
  assert_babble_needs_byte_R8: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> $past(byte_i));
endmodule

// File: rtl/eirq_gstop_det.sv
module eirq_gstop_det
  import eth_irq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic busy_i,
  output logic evt_o
);
  gs_state_t st_q, st_d;
  logic      fire;
  logic      evt_q;

  always_comb begin
    st_d = st_q;
    fire = 1'b0;
    case (st_q)
      GS_IDLE: if (req_i) begin
        if (!busy_i) begin fire = 1'b1; st_d = GS_HELD; end
        else st_d = GS_WAIT;
      end
      GS_WAIT: if (!req_i) st_d = GS_IDLE;
               else if (!busy_i) begin fire = 1'b1; st_d = GS_HELD; end
      GS_HELD: if (!req_i) st_d = GS_IDLE;
      default: st_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= GS_IDLE;
      evt_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      evt_q <= fire;
    end
  end

  assign evt_o = evt_q;

  assert_gstop_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> $past(req_i && !busy_i));
  assert_gstop_single_R10: assert property (@(posedge clk) disable iff (rst)
    evt_q |=> !evt_q);
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import eth_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ev_bits_t          set_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  ev_bits_t          wbits_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] OFF_EV   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(4);

  ev_bits_t           ev_q, mask_q, clr_vec;
  logic               irq_q;
  logic [REG_W-1:0]   rd_q;
  logic               hit_ev, hit_mask;

  assign hit_ev   = wr_i && (addr_i == OFF_EV);
  assign hit_mask = wr_i && (addr_i == OFF_MASK);
  assign clr_vec  = hit_ev ? wbits_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_q   <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      ev_q  <= (ev_q & ~clr_vec) | set_i;   // set beats clear
      if (hit_mask) mask_q <= wbits_i;
      irq_q <= |(ev_q & mask_q);
      case (addr_i)
        OFF_EV:   rd_q <= {ev_q, irq_q, {SUM_BIT{1'b0}}};
        OFF_MASK: rd_q <= {mask_q, {(SUM_BIT+1){1'b0}}};
        default:  rd_q <= '0;
      endcase
    end
  end

  assign rdata_o = rd_q;
  assign irq_o   = irq_q;

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (rst)
    (hit_ev && ((set_i & clr_vec) == '0)) |=> ((ev_q & $past(clr_vec)) == '0));
  assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((ev_q & $past(set_i)) == $past(set_i)));
  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    ((ev_q & mask_q) == '0) |=> !irq_q);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    rd_q[SUM_BIT-1:0] == '0);
endmodule

// File: rtl/eth_irq_ctrl.sv
module eth_irq_ctrl
  import eth_irq_pkg::*;
#(
  parameter int LEN_W  = 14,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hb_err_i,
  input  logic              tx_frame_i,
  input  logic              tx_buf_i,
  input  logic              rx_frame_i,
  input  logic              rx_buf_i,
  input  logic              mgmt_done_i,
  input  logic              bus_err_i,
  input  logic [LEN_W-1:0]  max_frame_len_i,
  input  logic              rx_sof_i,
  input  logic              rx_byte_i,
  input  logic              tx_sof_i,
  input  logic              tx_byte_i,
  input  logic              gstop_req_i,
  input  logic              tx_active_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  // index 0 = receive watchdog, index 1 = transmit watchdog
  logic [NUM_BABBLE-1:0] bab_sof, bab_byte, bab_evt;
  logic                  gs_evt;
  ev_bits_t              set_vec;
  logic                  unused_wdata;

  assign bab_sof  = {tx_sof_i, rx_sof_i};
  assign bab_byte = {tx_byte_i, rx_byte_i};

  for (genvar g = 0; g < NUM_BABBLE; g++) begin : g_babble
    eirq_babble_det #(.LEN_W(LEN_W)) u_det (
      .clk       (clk),
      .rst       (rst),
      .sof_i     (bab_sof[g]),
      .byte_i    (bab_byte[g]),
      .max_len_i (max_frame_len_i),
      .evt_o     (bab_evt[g])
    );
  end

  eirq_gstop_det u_gstop (
    .clk    (clk),
    .rst    (rst),
    .req_i  (gstop_req_i),
    .busy_i (tx_active_i),
    .evt_o  (gs_evt)
  );

  assign set_vec = {hb_err_i, bab_evt[0], bab_evt[1], gs_evt, tx_frame_i,
                    tx_buf_i, rx_frame_i, rx_buf_i, mgmt_done_i, bus_err_i};

  assign unused_wdata = ^reg_wdata_i[SUM_BIT:0];

  eirq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .set_i   (set_vec),
    .addr_i  (reg_addr_i),
    .wr_i    (reg_wr_i),
    .wbits_i (reg_wdata_i[EV_TOP:EV_LOW]),
    .rdata_o (reg_rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/eth_irq_ctrl_bench.sv
`timescale 1ns/1ps
module eth_irq_ctrl_bench;
  localparam int LEN_W  = 14;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst;
  logic hb, txf, txb, rxf, rxb, mg, be;
  logic [LEN_W-1:0] maxl;
  logic rxs, rxby, txs, txby, gsr, txa;
  logic [ADDR_W-1:0] addr;
  logic wr;
  logic [31:0] wd, rd;
  logic irq;

  always #2.5 clk = ~clk;

  eth_irq_ctrl #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_eth_irq_ctrl (
    .clk(clk), .rst(rst), .hb_err_i(hb), .tx_frame_i(txf), .tx_buf_i(txb),
    .rx_frame_i(rxf), .rx_buf_i(rxb), .mgmt_done_i(mg), .bus_err_i(be),
    .max_frame_len_i(maxl), .rx_sof_i(rxs), .rx_byte_i(rxby), .tx_sof_i(txs),
    .tx_byte_i(txby), .gstop_req_i(gsr), .tx_active_i(txa), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_wdata_i(wd), .reg_rdata_o(rd), .irq_o(irq));

  int vectors = 0;
  int errs = 0;

  // behavioural reference
  bit [9:0]  m_ev, m_mask, t_set, t_clr;
  bit        m_irq, t_irqn, cmp_on;
  bit [31:0] m_rdata;
  string     m_tag = "R1";
  int        m_rxc, m_txc, m_gst;
  bit        m_rxa, m_txa, m_rxp, m_txp, m_gsp;

  always @(posedge clk) begin
    if (rst) begin
      m_ev = 0; m_mask = 0; m_irq = 0; m_rdata = 0; m_tag = "R1";
      m_rxc = 0; m_txc = 0; m_rxa = 0; m_txa = 0;
      m_rxp = 0; m_txp = 0; m_gsp = 0; m_gst = 0;
      cmp_on = 1;
    end else begin
      if (addr == 0)      begin m_rdata = {m_ev, m_irq, 21'b0}; m_tag = "R2"; end
      else if (addr == 4) begin m_rdata = {m_mask, 22'b0};      m_tag = "R7"; end
      else                begin m_rdata = 0;                    m_tag = "R7"; end
      t_set  = {hb, m_rxp, m_txp, m_gsp, txf, txb, rxf, rxb, mg, be};
      t_clr  = (wr && addr == 0) ? wd[31:22] : 10'b0;
      t_irqn = |(m_ev & m_mask);
      m_ev   = (m_ev & ~t_clr) | t_set;
      if (wr && addr == 4) m_mask = wd[31:22];
      m_irq  = t_irqn;
      m_rxp = 0;
      if (rxs) begin m_rxc = 0; m_rxa = 1; end
      if (rxby && m_rxa) begin
        if (m_rxc == int'(maxl)) begin m_rxp = 1; m_rxa = 0; end else m_rxc++;
      end
      m_txp = 0;
      if (txs) begin m_txc = 0; m_txa = 1; end
      if (txby && m_txa) begin
        if (m_txc == int'(maxl)) begin m_txp = 1; m_txa = 0; end else m_txc++;
      end
      m_gsp = 0;
      if (m_gst == 0) begin
        if (gsr) begin if (!txa) begin m_gsp = 1; m_gst = 2; end else m_gst = 1; end
      end else if (m_gst == 1) begin
        if (!gsr) m_gst = 0; else if (!txa) begin m_gsp = 1; m_gst = 2; end
      end else if (!gsr) m_gst = 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      vectors++;
      if (irq !== m_irq) begin
        errs++; $display("FAIL R5 irq got %b expected %b", irq, m_irq);
      end
      vectors++;
      if (rd !== m_rdata) begin
        errs++; $display("FAIL %s rdata got %h expected %h", m_tag, rd, m_rdata);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      errs++; $display("FAIL %s got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet();
    hb = 0; txf = 0; txb = 0; rxf = 0; rxb = 0; mg = 0; be = 0;
    rxs = 0; rxby = 0; txs = 0; txby = 0; wr = 0; wd = 0;
  endtask

  task automatic clear_all();
    addr = 0; wr = 1; wd = 32'hFFC0_0000; tick(); wr = 0; wd = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL R1 watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst = 1; quiet(); gsr = 0; txa = 0; addr = 0; maxl = 5;
    tick(3); rst = 0; tick();
    chk(rd, 0, "R1 event after reset"); chk({31'b0, irq}, 0, "R1 irq after reset");
    addr = 4; tick(); chk(rd, 0, "R1 mask after reset");

    addr = 0; txf = 1; tick(); txf = 0; tick();
    chk(rd, 32'h0800_0000, "R2 transmit frame bit");
    wr = 1; wd = 0; tick(); wr = 0; tick();
    chk(rd, 32'h0800_0000, "R3 zero write keeps bit");
    wr = 1; wd = 32'h0800_0000; tick(); wr = 0; tick();
    chk(rd, 0, "R3 one write clears bit");

    rxb = 1; wr = 1; wd = 32'h0100_0000; tick(); rxb = 0; wr = 0; tick();
    chk(rd, 32'h0100_0000, "R4 set beats clear");
    clear_all(); tick();

    addr = 4; wr = 1; wd = 32'hFFFF_FFFF; tick(); wr = 0; tick();
    chk(rd, 32'hFFC0_0000, "R7 mask readback");
    addr = 0; be = 1; tick(); be = 0; tick();
    chk({31'b0, irq}, 1, "R5 irq raised");
    tick(); chk(rd, 32'h0060_0000, "R6 summary bit set");
    addr = 4; wr = 1; wd = 0; tick(); wr = 0; addr = 0; tick(); tick();
    chk(rd, 32'h0040_0000, "R6 masked event, summary low");
    chk({31'b0, irq}, 0, "R5 irq dropped after mask");
    wr = 1; wd = 32'h0020_0000; tick(); addr = 8; wd = 32'hFFFF_FFFF; tick();
    wr = 0; addr = 0; tick(); tick();
    chk(rd, 32'h0040_0000, "R7 ignored writes");
    addr = 8; tick(); chk(rd, 0, "R7 unmapped read");
    addr = 4; tick(); chk(rd, 0, "R7 mask untouched");
    clear_all(); tick();

    rxs = 1; rxby = 1; tick(); rxs = 0; tick(5); rxby = 0; tick(2);
    chk(rd, 32'h4000_0000, "R8 oversize receive");
    clear_all(); rxby = 1; tick(3); rxby = 0; tick(2);
    chk(rd, 0, "R8 disarmed without start");
    rxs = 1; rxby = 1; tick(); rxs = 0; tick(4); rxby = 0; tick(2);
    chk(rd, 0, "R8 frame at ceiling");

    maxl = 2;
    txs = 1; txby = 1; tick(); txs = 0; tick(2); txby = 0; tick(2);
    chk(rd, 32'h2000_0000, "R9 oversize transmit");
    clear_all(); txby = 1; tick(4); txby = 0; tick(2);
    chk(rd, 0, "R9 once per frame");

    txa = 1; gsr = 1; tick(3); chk(rd, 0, "R10 waits for frame end");
    txa = 0; tick(3); chk(rd, 32'h1000_0000, "R10 stop complete");
    clear_all(); tick(2); chk(rd, 0, "R10 no repeat while held");
    gsr = 0; tick(); gsr = 1; tick(3);
    chk(rd, 32'h1000_0000, "R10 immediate when idle");
    clear_all(); gsr = 0; tick(); txa = 1; gsr = 1; tick(); gsr = 0; tick();
    txa = 0; tick(3); chk(rd, 0, "R10 cancelled request");

    maxl = 3;
    for (int i = 0; i < 4000; i++) begin
      hb = ($urandom_range(7) == 0); txf = ($urandom_range(7) == 0);
      txb = ($urandom_range(7) == 0); rxf = ($urandom_range(7) == 0);
      rxb = ($urandom_range(7) == 0); mg = ($urandom_range(7) == 0);
      be = ($urandom_range(7) == 0);
      rxs = ($urandom_range(19) == 0); rxby = $urandom_range(1);
      txs = ($urandom_range(19) == 0); txby = $urandom_range(1);
      if ($urandom_range(29) == 0) gsr = ~gsr;
      if ($urandom_range(9) == 0) txa = ~txa;
      wr = ($urandom_range(5) == 0);
      case ($urandom_range(2))
        0: addr = 0;
        1: addr = 4;
        default: addr = 8;
      endcase
      wd = $urandom;
      tick();
    end
    quiet(); tick(3);
    summary();
    $finish;
  end
endmodule